// File: doc/BRIEF.md
# Masked Interrupt Vector Priority Encoder

This block collects sixteen interrupt sources into one request line for a processor. A one-cycle pulse on a source input latches a pending bit in a flag register. A per-source mask register and a single global enable decide whether pending bits reach the request output. When the processor acknowledges, the block returns the vector address of the winning source in the same cycle and clears that source's pending bit on the acknowledging clock edge. The winner is the unmasked pending source with the lowest index.

Vector addresses are even and do not grow linearly with the source index. Four groups of sources map into a fixed, out-of-order vector layout. The flag, mask and priority registers are 16 bits wide. Software reaches each of them as two bytes through a small byte-wide register port. The priority register is plain storage and does not affect which source wins.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the flag register reads 0x0000, the mask and priority registers read 0xFFFF, and `irq_req` is low.
- R2: `irq_req` is high exactly when `glb_en` is high and at least one bit of (flag AND NOT mask) is set. A mask bit of 1 blocks its source.
- R3: While `ack` is high and a request is present, `ack_vector` holds the vector of the lowest-indexed pending unmasked source.
- R4: The vector for source i is 0x06+2i for i in 0..3, 0x14+2(i-4) for i in 4..9, 0x0E+2(i-10) for i in 10..12, and 0x20+2(i-13) for i in 13..15.
- R5: On the clock edge where `ack` is high and a request is present, the winning source's flag bit clears and no other flag bit changes.
- R6: An `ack` with no request present (including when `glb_en` is low) drives `ack_vector` to 0x00 and leaves every flag bit unchanged.
- R7: A high bit on `src_set` sets its flag bit at the next edge. The set wins over an acknowledge clear of the same bit and over a software write of the same byte in the same cycle.
- R8: The register port maps address 0 and 1 to flag bits 7:0 and 15:8, address 2 and 3 to mask bits 7:0 and 15:8, and address 4 and 5 to priority bits 7:0 and 15:8. A write changes only the addressed byte. `rdata` shows the addressed byte combinationally. Addresses 6 and 7 read 0xFF and ignore writes.
- R9: The contents of the priority register have no effect on which source is chosen or on the returned vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 16 | Per-source set pulses |
| glb_en | input | 1 | Global enable for maskable requests |
| wr_en | input | 1 | Register byte write strobe |
| addr | input | 3 | Register byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr` |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_vector | output | 8 | Vector address while `ack` is high |

## Verification
The assertions on counting and stability of the flag register only apply in cycles with no software write and no set pulse, so that the acknowledge alone explains any change. The bench keeps `ack`, `src_set` and `wr_en` apart where a check depends on that. It overlaps them only in the scenario aimed at set-wins ordering. Every input is driven one time unit after a rising edge, and `ack` is held for exactly one cycle per acknowledge. Combinational outputs are read on the falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC   = 16;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = 8;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_BYTES = NUM_SRC / BYTE_W;

    // Vector layout: group start index and base address for each group
    localparam int GRP_B_LO  = 4;
    localparam int GRP_C_LO  = 10;
    localparam int GRP_D_LO  = 13;
    localparam int BASE_A    = 'h06;
    localparam int BASE_B    = 'h14;
    localparam int BASE_C    = 'h0E;
    localparam int BASE_D    = 'h20;
    localparam int VEC_STEP  = 2;

    // Register select carried in addr[2:1]
    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PRIO = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] prio;
    } ctrl_regs_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_set,
    input  logic [NUM_SRC-1:0]     ack_clr,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    output logic [NUM_SRC-1:0]     flag_q,
    output logic [NUM_SRC-1:0]     mask_q
);
    ctrl_regs_t st_d, st_q;
    reg_sel_e   sel;
    int         byte_pos;

    assign sel      = reg_sel_e'(addr[2:1]);
    assign byte_pos = int'(addr[0]) * BYTE_W;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_FLAG: st_d.flag[byte_pos +: BYTE_W] = wdata;
                SEL_MASK: st_d.mask[byte_pos +: BYTE_W] = wdata;
                SEL_PRIO: st_d.prio[byte_pos +: BYTE_W] = wdata;
                default:  ;
            endcase
        end
        // acknowledge clear first, hardware set last so the set wins
        st_d.flag = (st_d.flag & ~ack_clr) | src_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.mask <= '1;
            st_q.prio <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAG: rdata = st_q.flag[byte_pos +: BYTE_W];
            SEL_MASK: rdata = st_q.mask[byte_pos +: BYTE_W];
            SEL_PRIO: rdata = st_q.prio[byte_pos +: BYTE_W];
            default:  rdata = '1;
        endcase
    end

    assign flag_q = st_q.flag;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] win_onehot,
    output logic [IDX_W-1:0]   win_idx,
    output logic               any_req
);
    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign win_onehot[g] = req[g] & ~seen[g];
        assign seen[g+1]     = seen[g] | req[g];
    end

    assign any_req = seen[NUM_SRC];

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win_onehot[i]) win_idx = win_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
    import irq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);
    int i;
    assign i = int'(idx);

    always_comb begin
        if (i < GRP_B_LO)
            vec = VEC_W'(BASE_A + VEC_STEP * i);
        else if (i < GRP_C_LO)
            vec = VEC_W'(BASE_B + VEC_STEP * (i - GRP_B_LO));
        else if (i < GRP_D_LO)
            vec = VEC_W'(BASE_C + VEC_STEP * (i - GRP_C_LO));
        else
            vec = VEC_W'(BASE_D + VEC_STEP * (i - GRP_D_LO));
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_set,
    input  logic                   glb_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    input  logic                   ack,
    output logic                   irq_req,
    output logic [VEC_W-1:0]       ack_vector
);
    logic [NUM_SRC-1:0] flag_q, mask_q, live_req, win_onehot, ack_clr;
    logic [IDX_W-1:0]   win_idx;
    logic [VEC_W-1:0]   win_vec;
    logic               any_req, take;

    irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_set (src_set),
        .ack_clr (ack_clr),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .flag_q  (flag_q),
        .mask_q  (mask_q)
    );

    assign live_req = flag_q & ~mask_q & {NUM_SRC{glb_en}};

    irq_lowest_pick u_pick (
        .req        (live_req),
        .win_onehot (win_onehot),
        .win_idx    (win_idx),
        .any_req    (any_req)
    );

    irq_vec_map u_map (
        .idx (win_idx),
        .vec (win_vec)
    );

    assign take       = ack & any_req;
    assign ack_clr    = take ? win_onehot : '0;
    assign irq_req    = any_req;
    assign ack_vector = take ? win_vec : '0;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               glb_en,
    input  logic               wr_en,
    input  logic               ack,
    input  logic               irq_req,
    input  logic [VEC_W-1:0]   ack_vector,
    input  logic [NUM_SRC-1:0] flag_q
);
    a_r2_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_en);

    a_r4_vector_in_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |-> (ack_vector[0] == 1'b0 && ack_vector >= VEC_W'(BASE_A)
                              && ack_vector <= VEC_W'(BASE_D + 2 * VEC_STEP)));

    a_r5_ack_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && src_set == '0 && !wr_en)
        |=> ($countones(flag_q) == $past($countones(flag_q)) - 1));

    a_r6_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req) |-> ack_vector == '0);

    a_r6_idle_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req && src_set == '0 && !wr_en) |=> $stable(flag_q));

    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> (($past(src_set) & ~flag_q) == '0));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_set    (src_set),
    .glb_en     (glb_en),
    .wr_en      (wr_en),
    .ack        (ack),
    .irq_req    (irq_req),
    .ack_vector (ack_vector),
    .flag_q     (flag_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_set = '0;
    logic        glb_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ack = 1'b0;
    logic        irq_req;
    logic [7:0]  ack_vector;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .glb_en(glb_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ack(ack), .irq_req(irq_req), .ack_vector(ack_vector)
    );

    function automatic logic [7:0] exp_vec(int i);
        logic [7:0] t [16] = '{8'h06, 8'h08, 8'h0A, 8'h0C, 8'h14, 8'h16, 8'h18, 8'h1A,
                               8'h1C, 8'h1E, 8'h0E, 8'h10, 8'h12, 8'h20, 8'h22, 8'h24};
        return t[i];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd16(logic [2:0] a, output logic [15:0] v);
        addr = a; #1; v[7:0] = rdata;
        addr = a + 3'd1; #1; v[15:8] = rdata;
    endtask

    task automatic do_ack(string req, logic [7:0] exp);
        @(negedge clk);
        ack = 1'b1; #1;
        chk(req, ack_vector, exp);
        step();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        rd16(0, v); chk("R1 flag", v, 16'h0000);
        rd16(2, v); chk("R1 mask", v, 16'hFFFF);
        rd16(4, v); chk("R1 prio", v, 16'hFFFF);
        glb_en = 1'b1;
        src_set = 16'h0001; step(); src_set = '0;
        @(negedge clk); chk("R1 masked after reset", irq_req, 1'b0);
        wr(0, 8'h00); glb_en = 1'b0;
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(3, 8'h12); rd16(2, v); chk("R8 mask high byte", v, 16'h12FF);
        wr(4, 8'h34); rd16(4, v); chk("R8 prio low byte", v, 16'hFF34);
        wr(1, 8'h80); rd16(0, v); chk("R8 flag high byte", v, 16'h8000);
        wr(6, 8'h55);
        addr = 3'd6; #1; chk("R8 addr6 reads FF", rdata, 8'hFF);
        addr = 3'd7; #1; chk("R8 addr7 reads FF", rdata, 8'hFF);
        rd16(0, v); chk("R8 flag untouched by addr6", v, 16'h8000);
        rd16(2, v); chk("R8 mask untouched by addr6", v, 16'h12FF);
        wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'hFF);
    endtask

    task automatic t_vectors();
        logic [15:0] v;
        glb_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            src_set = 16'(1) << i; step(); src_set = '0;
            @(negedge clk); chk($sformatf("R2 req bit%0d", i), irq_req, 1'b1);
            do_ack($sformatf("R4 vector bit%0d", i), exp_vec(i));
            rd16(0, v); chk($sformatf("R5 cleared bit%0d", i), v, 16'h0000);
        end
    endtask

    task automatic t_order();
        logic [15:0] v;
        src_set = 16'hA480; step(); src_set = '0;
        do_ack("R3 first bit7", 8'h1A);
        rd16(0, v); chk("R5 after bit7", v, 16'hA400);
        do_ack("R3 next bit10", 8'h0E);
        do_ack("R3 next bit13", 8'h20);
        rd16(0, v); chk("R5 after bit13", v, 16'h8000);
        do_ack("R3 last bit15", 8'h24);
        src_set = 16'h2480; step(); src_set = '0;
        wr(2, 8'h80);
        do_ack("R3 masked bit7 skipped", 8'h0E);
        do_ack("R3 then bit13", 8'h20);
        @(negedge clk); chk("R2 only masked pending", irq_req, 1'b0);
        do_ack("R6 idle vector", 8'h00);
        rd16(0, v); chk("R6 flags kept", v, 16'h0080);
        wr(2, 8'h00);
        glb_en = 1'b0;
        @(negedge clk); chk("R2 disabled", irq_req, 1'b0);
        do_ack("R6 disabled vector", 8'h00);
        rd16(0, v); chk("R6 disabled flags kept", v, 16'h0080);
        glb_en = 1'b1;
        @(negedge clk); chk("R2 reenabled", irq_req, 1'b1);
        do_ack("R4 bit7 after enable", 8'h1A);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        src_set = 16'h0028; step(); src_set = '0;
        @(negedge clk); ack = 1'b1; #1;
        chk("R3 vector with colliding set", ack_vector, 8'h0C);
        src_set = 16'h0008;
        step(); ack = 1'b0; src_set = '0;
        rd16(0, v); chk("R7 set beats ack clear", v, 16'h0028);
        wr_en = 1'b1; addr = 3'd0; wdata = 8'h00; src_set = 16'h0002;
        step(); wr_en = 1'b0; src_set = '0;
        rd16(0, v); chk("R7 set beats write", v, 16'h0002);
        wr(0, 8'h00);
    endtask

    task automatic t_prio();
        src_set = 16'h4004; step(); src_set = '0;
        wr(4, 8'h00); wr(5, 8'hBF);
        @(negedge clk); ack = 1'b1; #1;
        chk("R9 prio 0xBF00", ack_vector, 8'h0A);
        ack = 1'b0;
        wr(4, 8'h04); wr(5, 8'h00);
        do_ack("R9 prio 0x0004", 8'h0A);
        do_ack("R9 remaining bit14", 8'h22);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_vectors();
        t_order();
        t_set_wins();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule